// File: doc/BRIEF.md
# PLL Divider Reprogramming Sequencer

This block changes the divider settings of a PLL without ever passing an unsettled clock downstream. It drives the PLL's active-low reset pin, its bypass pin, its lock-source select pin and the divider buses (feedback multiplier, input pre-divider, output post-divider and a 16-bit fractional word). A request names an operation and, for a rate change, the new divider values. The sequencer compares the new multiplier and pre-divider with the values currently on its outputs. If both are unchanged, it only rewrites the post-divider and the fractional word in one step. Otherwise it runs a full relock: it selects the PLL output as lock source, puts the PLL in reset, switches to bypass, loads the dividers, holds reset for a timed interval, releases reset, waits for lock with a bounded timeout, and then leaves bypass.

Two more operations cover power control. Power-up releases reset behind bypass and waits for lock. Power-down pulls reset low. Time is counted in clock cycles, using a parameter that gives the number of cycles per microsecond. The lock input passes through a synchronizer before the state machine uses it. The handshake is a one-cycle request strobe, a busy level while a multi-cycle sequence runs, and a one-cycle done pulse with an error flag.

Top module: `pll_reseq`

## Requirements
- R1: After reset, pll_resetn, pll_bypass, pll_lock_sel, all divider outputs, busy, done and err are all 0.
- R2: A set request (op code 0) with a non-zero pre-divider, whose multiplier and pre-divider equal the current outputs, updates div_post and div_frac at the accepting edge. done is high in the next cycle. pll_resetn, pll_bypass and pll_lock_sel do not change, and busy stays low.
- R3: A set request that changes the multiplier or the pre-divider produces these steps, each on a strictly later clock edge than the one before: pll_lock_sel high, then pll_resetn low, then pll_bypass high, then all dividers loaded together, then pll_resetn high, then pll_bypass low.
- R4: After the dividers are loaded, pll_resetn stays low for exactly HOLD_US*CLKS_PER_US cycles.
- R5: After reset is released, a synchronized lock seen within TIMEOUT_US*CLKS_PER_US cycles ends the sequence with done, no err, and pll_bypass low. If lock is seen in the cycle where the timeout expires, lock wins.
- R6: If lock is not seen in time, the sequence ends with done and err high, pll_bypass stays high and pll_resetn stays high.
- R7: A power-up request (op code 1) while pll_resetn is high only pulses done, with no output change. While pll_resetn is low, it raises pll_bypass, then raises pll_resetn on a later edge, waits for lock as in R5, and clears pll_bypass.
- R8: A power-down request (op code 2) drives pll_resetn low and pulses done in the next cycle. It leaves pll_bypass and the dividers unchanged.
- R9: A set request with pre-divider 0, and any request with op code 3, pulses done together with err and changes no output.
- R10: A request that arrives while busy is high is ignored. The dividers applied at the end of the sequence are those of the accepted request.
- R11: done is high for a single cycle, and busy is low in that cycle.
- R12: The fractional word is loaded together with the integer dividers on the relock path, and on the fast path of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_op | input | 2 | 0 set dividers, 1 power-up, 2 power-down, 3 reserved |
| req_main | input | MAIN_W | Requested feedback multiplier |
| req_pre | input | PRE_W | Requested pre-divider (0 is invalid) |
| req_post | input | POST_W | Requested post-divider code |
| req_frac | input | FRAC_W | Requested fractional word |
| pll_lock | input | 1 | Lock indication from the PLL (asynchronous) |
| busy | output | 1 | A multi-cycle sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Qualifies done: rejected request or lock timeout |
| pll_resetn | output | 1 | PLL reset, active low |
| pll_bypass | output | 1 | PLL bypass enable |
| pll_lock_sel | output | 1 | Selects the PLL output as lock source |
| div_main | output | MAIN_W | Applied multiplier |
| div_pre | output | PRE_W | Applied pre-divider |
| div_post | output | POST_W | Applied post-divider |
| div_frac | output | FRAC_W | Applied fractional word (0 when FRACTIONAL is 0) |

## Verification
The lock wait and the timeout expiry can fall in the same cycle. The bench provokes this by setting the PLL model's lock delay so that the synchronized lock first reaches the state machine exactly at the expiry edge, three cycles of lock-to-decision latency before the limit. It expects a clean completion there and a timeout error when the delay is one cycle longer. A second overlap, a new request arriving during a running relock, is provoked mid-sequence and judged by the dividers that are left applied.

// File: rtl/pll_reseq_pkg.sv
package pll_reseq_pkg;

  typedef enum logic [1:0] {
    OP_SET       = 2'd0,
    OP_POWERUP   = 2'd1,
    OP_POWERDOWN = 2'd2,
    OP_RESERVED  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST_ON,
    ST_BYP_ON,
    ST_LOAD,
    ST_HOLD,
    ST_PWR_REL,
    ST_WAIT
  } st_e;

endpackage

// File: rtl/pll_reseq_sync.sv
module pll_reseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/pll_reseq_timer.sv
module pll_reseq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/pll_reseq_fsm.sv
module pll_reseq_fsm
  import pll_reseq_pkg::*;
#(
  parameter int MAIN_W   = 10,
  parameter int PRE_W    = 6,
  parameter int POST_W   = 3,
  parameter int FRAC_W   = 16,
  parameter int CNT_W    = 8,
  parameter int HOLD_CYC = 300,
  parameter int TO_CYC   = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [MAIN_W-1:0] req_main,
  input  logic [PRE_W-1:0]  req_pre,
  input  logic [POST_W-1:0] req_post,
  input  logic [FRAC_W-1:0] req_frac,
  input  logic              lock_s,
  input  logic              tmr_expired,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  output logic              busy,
  output logic              done_o,
  output logic              err_o,
  output logic              pll_resetn,
  output logic              pll_bypass,
  output logic              pll_lock_sel,
  output logic [MAIN_W-1:0] div_main,
  output logic [PRE_W-1:0]  div_pre,
  output logic [POST_W-1:0] div_post,
  output logic [FRAC_W-1:0] frac_q
);

  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] TO_LOAD   = CNT_W'(TO_CYC - 1);

  st_e               state;
  logic [MAIN_W-1:0] pend_main;
  logic [PRE_W-1:0]  pend_pre;
  logic [POST_W-1:0] pend_post;
  logic [FRAC_W-1:0] pend_frac;

  // Timer programming: hold window on leaving LOAD, lock window on reset release
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (state == ST_LOAD) begin
      tmr_load = 1'b1;
      tmr_val  = HOLD_LOAD;
    end else if ((state == ST_HOLD && tmr_expired) || state == ST_PWR_REL) begin
      tmr_load = 1'b1;
      tmr_val  = TO_LOAD;
    end
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      done_o       <= 1'b0;
      err_o        <= 1'b0;
      pll_resetn   <= 1'b0;
      pll_bypass   <= 1'b0;
      pll_lock_sel <= 1'b0;
      div_main     <= '0;
      div_pre      <= '0;
      div_post     <= '0;
      frac_q       <= '0;
      pend_main    <= '0;
      pend_pre     <= '0;
      pend_post    <= '0;
      pend_frac    <= '0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            unique case (op_e'(req_op))
              OP_SET: begin
                if (req_pre == '0) begin
                  done_o <= 1'b1;
                  err_o  <= 1'b1;
                end else if (req_main == div_main && req_pre == div_pre) begin
                  div_post <= req_post;
                  frac_q   <= req_frac;
                  done_o   <= 1'b1;
                end else begin
                  pend_main    <= req_main;
                  pend_pre     <= req_pre;
                  pend_post    <= req_post;
                  pend_frac    <= req_frac;
                  pll_lock_sel <= 1'b1;
                  state        <= ST_RST_ON;
                end
              end
              OP_POWERUP: begin
                if (pll_resetn) begin
                  done_o <= 1'b1;
                end else begin
                  pll_bypass <= 1'b1;
                  state      <= ST_PWR_REL;
                end
              end
              OP_POWERDOWN: begin
                pll_resetn <= 1'b0;
                done_o     <= 1'b1;
              end
              default: begin
                done_o <= 1'b1;
                err_o  <= 1'b1;
              end
            endcase
          end
        end
        ST_RST_ON: begin
          pll_resetn <= 1'b0;
          state      <= ST_BYP_ON;
        end
        ST_BYP_ON: begin
          pll_bypass <= 1'b1;
          state      <= ST_LOAD;
        end
        ST_LOAD: begin
          div_main <= pend_main;
          div_pre  <= pend_pre;
          div_post <= pend_post;
          frac_q   <= pend_frac;
          state    <= ST_HOLD;
        end
        ST_HOLD: begin
          if (tmr_expired) begin
            pll_resetn <= 1'b1;
            state      <= ST_WAIT;
          end
        end
        ST_PWR_REL: begin
          pll_resetn <= 1'b1;
          state      <= ST_WAIT;
        end
        ST_WAIT: begin
          if (lock_s) begin
            pll_bypass <= 1'b0;
            done_o     <= 1'b1;
            state      <= ST_IDLE;
          end else if (tmr_expired) begin
            done_o <= 1'b1;
            err_o  <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3/R4: reset leaves the hold phase only once the shared timer has run out
  a_r4_release_after_hold: assert property (@(posedge clk) disable iff (rst)
    ($rose(pll_resetn) && $past(state) == ST_HOLD) |-> $past(tmr_expired));

  // R5: bypass is dropped only on a synchronized lock
  a_r5_bypass_off_on_lock: assert property (@(posedge clk) disable iff (rst)
    $fell(pll_bypass) |-> $past(lock_s));

  // R6: a lock timeout leaves the PLL out of reset and bypassed
  a_r6_timeout_keeps_bypass: assert property (@(posedge clk) disable iff (rst)
    (err_o && $past(state) == ST_WAIT) |-> (pll_bypass && pll_resetn));

  // R9: a rejected request leaves every control pin and divider as it was
  a_r9_reject_no_change: assert property (@(posedge clk) disable iff (rst)
    (err_o && $past(state) == ST_IDLE) |->
      ($stable(pll_resetn) && $stable(pll_bypass) && $stable(pll_lock_sel) &&
       $stable(div_main) && $stable(div_pre) && $stable(div_post)));

  // R10: outside the load step a running sequence never touches the dividers
  a_r10_div_frozen_when_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && state != ST_LOAD) |=>
      ($stable(div_main) && $stable(div_pre) && $stable(div_post) && $stable(frac_q)));

  // R11: done is a single-cycle pulse and never overlaps busy
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r11_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy);

endmodule

// File: rtl/pll_reseq.sv
module pll_reseq #(
  parameter int CLKS_PER_US = 100,
  parameter int HOLD_US     = 3,
  parameter int TIMEOUT_US  = 10000,
  parameter int MAIN_W      = 10,
  parameter int PRE_W       = 6,
  parameter int POST_W      = 3,
  parameter int FRAC_W      = 16,
  parameter int FRACTIONAL  = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [MAIN_W-1:0] req_main,
  input  logic [PRE_W-1:0]  req_pre,
  input  logic [POST_W-1:0] req_post,
  input  logic [FRAC_W-1:0] req_frac,
  input  logic              pll_lock,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              pll_resetn,
  output logic              pll_bypass,
  output logic              pll_lock_sel,
  output logic [MAIN_W-1:0] div_main,
  output logic [PRE_W-1:0]  div_pre,
  output logic [POST_W-1:0] div_post,
  output logic [FRAC_W-1:0] div_frac
);

  localparam int HOLD_CYC = HOLD_US * CLKS_PER_US;
  localparam int TO_CYC   = TIMEOUT_US * CLKS_PER_US;
  localparam int MAX_CYC  = (HOLD_CYC > TO_CYC) ? HOLD_CYC : TO_CYC;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  logic             lock_s;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic [FRAC_W-1:0] frac_q;

  pll_reseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pll_lock),
    .q   (lock_s)
  );

  pll_reseq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  pll_reseq_fsm #(
    .MAIN_W   (MAIN_W),
    .PRE_W    (PRE_W),
    .POST_W   (POST_W),
    .FRAC_W   (FRAC_W),
    .CNT_W    (CNT_W),
    .HOLD_CYC (HOLD_CYC),
    .TO_CYC   (TO_CYC)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_op       (req_op),
    .req_main     (req_main),
    .req_pre      (req_pre),
    .req_post     (req_post),
    .req_frac     (req_frac),
    .lock_s       (lock_s),
    .tmr_expired  (tmr_expired),
    .tmr_load     (tmr_load),
    .tmr_val      (tmr_val),
    .busy         (busy),
    .done_o       (done),
    .err_o        (err),
    .pll_resetn   (pll_resetn),
    .pll_bypass   (pll_bypass),
    .pll_lock_sel (pll_lock_sel),
    .div_main     (div_main),
    .div_pre      (div_pre),
    .div_post     (div_post),
    .frac_q       (frac_q)
  );

  // R12: the fractional word reaches the pins only in the fractional variant
  generate
    if (FRACTIONAL != 0) begin : g_frac
      assign div_frac = frac_q;
    end else begin : g_int
      assign div_frac = '0;
    end
  endgenerate

endmodule

// File: tb/pll_reseq_tb.sv
module pll_reseq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 2;
  localparam int HOLD_US    = 3;
  localparam int TO_US      = 40;
  localparam int HOLD_CYC   = HOLD_US * CPU;
  localparam int TO_CYC     = TO_US * CPU;
  localparam int LIMIT      = 400;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [9:0]  req_main = '0;
  logic [5:0]  req_pre = '0;
  logic [2:0]  req_post = '0;
  logic [15:0] req_frac = '0;
  logic        pll_lock = 1'b0;
  logic        busy, done, err, pll_resetn, pll_bypass, pll_lock_sel;
  logic [9:0]  div_main;
  logic [5:0]  div_pre;
  logic [2:0]  div_post;
  logic [15:0] div_frac;

  int total = 0;
  int fails = 0;
  int lock_dly = 5;
  int lock_cnt = 0;

  // run-time observations
  int t_rf, t_br, t_ld, t_rr, t_bf, hold_n, n_run;
  bit lsel_at_rf, got_done, got_err, saw_busy;
  logic p_resetn, p_bypass;
  logic [9:0] p_main;
  logic [5:0] p_pre;
  logic [9:0] e_main;
  logic [5:0] e_pre;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_reseq #(
    .CLKS_PER_US (CPU),
    .HOLD_US     (HOLD_US),
    .TIMEOUT_US  (TO_US)
  ) u_dut (
    .clk (clk), .rst (rst), .req_valid (req_valid), .req_op (req_op),
    .req_main (req_main), .req_pre (req_pre), .req_post (req_post),
    .req_frac (req_frac), .pll_lock (pll_lock), .busy (busy), .done (done),
    .err (err), .pll_resetn (pll_resetn), .pll_bypass (pll_bypass),
    .pll_lock_sel (pll_lock_sel), .div_main (div_main), .div_pre (div_pre),
    .div_post (div_post), .div_frac (div_frac)
  );

  // PLL model: lock rises lock_dly edges after reset is seen released
  always @(posedge clk) begin
    if (!pll_resetn) begin
      lock_cnt <= 0;
      pll_lock <= 1'b0;
    end else begin
      lock_cnt <= lock_cnt + 1;
      pll_lock <= (lock_cnt + 1 >= lock_dly);
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic samp(input int n);
    if (busy) saw_busy = 1'b1;
    if (p_resetn && !pll_resetn && t_rf < 0) begin
      t_rf = n;
      lsel_at_rf = pll_lock_sel;
    end
    if (!p_bypass && pll_bypass && t_br < 0) t_br = n;
    if ((div_main != p_main || div_pre != p_pre) && t_ld < 0) t_ld = n;
    if (!p_resetn && pll_resetn && t_rr < 0) t_rr = n;
    if (p_bypass && !pll_bypass && t_bf < 0) t_bf = n;
    if (!pll_resetn && div_main == e_main && div_pre == e_pre) hold_n++;
    p_resetn = pll_resetn;
    p_bypass = pll_bypass;
    p_main   = div_main;
    p_pre    = div_pre;
  endtask

  // Drive one request at a negedge and follow it to done
  task automatic run(input logic [1:0] op, input logic [9:0] m, input logic [5:0] p,
                     input logic [2:0] s, input logic [15:0] f, input bit inject);
    int n;
    t_rf = -1; t_br = -1; t_ld = -1; t_rr = -1; t_bf = -1; hold_n = 0;
    lsel_at_rf = 1'b0; saw_busy = 1'b0;
    p_resetn = pll_resetn; p_bypass = pll_bypass; p_main = div_main; p_pre = div_pre;
    e_main = m; e_pre = p;
    req_op = op; req_main = m; req_pre = p; req_post = s; req_frac = f;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    samp(0);
    while (!done && n < LIMIT) begin
      if (inject && n == 8) begin
        req_op = 2'd0; req_main = 10'd7; req_pre = 6'd2; req_post = 3'd1;
        req_frac = 16'h1234; req_valid = 1'b1;
      end
      if (inject && n == 9) req_valid = 1'b0;
      @(negedge clk);
      n++;
      samp(n);
    end
    req_valid = 1'b0;
    n_run = n;
    got_done = done;
    got_err = err;
    if (!done) chk("R11 watchdog: request never completed", 0, 1);
    @(negedge clk);
    chk("R11 done is a single pulse", done, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 pll_resetn", pll_resetn, 0);
    chk("R1 pll_bypass", pll_bypass, 0);
    chk("R1 pll_lock_sel", pll_lock_sel, 0);
    chk("R1 dividers", {div_main, div_pre, div_post, div_frac}, 0);
    chk("R1 busy/done/err", {busy, done, err}, 0);

    // R7 power-up from reset
    lock_dly = 5;
    run(2'd1, 0, 0, 0, 0, 0);
    chk("R7 power-up no err", got_err, 0);
    chk("R7 power-up order", (t_br >= 0 && t_rr > t_br && t_bf > t_rr), 1);
    chk("R7 power-up final pins", {pll_resetn, pll_bypass}, 2'b10);

    // R7 power-up when already running
    run(2'd1, 0, 0, 0, 0, 0);
    chk("R7 power-up noop immediate done", n_run, 0);
    chk("R7 power-up noop pins", {pll_resetn, pll_bypass, busy}, 3'b100);

    // R3 R4 R5 R12 full relock sweep over lock delays and settings
    for (int i = 0; i < 4; i++) begin
      logic [9:0]  m;
      logic [5:0]  p;
      logic [2:0]  s;
      logic [15:0] f;
      m = 10'(100 + 37 * i);
      p = 6'(1 + 20 * i);
      s = 3'(i + 1);
      f = 16'(1000 * i + 9);
      lock_dly = (i == 0) ? 1 : (i == 1) ? 4 : (i == 2) ? 12 : 30;
      run(2'd0, m, p, s, f, 0);
      chk("R3 lock_sel high before reset", lsel_at_rf, 1);
      chk("R3 step order", (t_rf >= 0 && t_br > t_rf && t_ld > t_br &&
                            t_rr > t_ld && t_bf > t_rr), 1);
      chk("R4 reset hold cycles", hold_n, HOLD_CYC);
      chk("R5 no err on lock", got_err, 0);
      chk("R5 bypass off after lock", pll_bypass, 0);
      chk("R12 dividers and fraction applied", {div_main, div_pre, div_post, div_frac},
          {m, p, s, f});
    end

    // R2 R12 fast path sweep: every post code with a fraction derived from it
    for (int s = 0; s < 8; s++) begin
      logic [9:0] m0;
      logic [5:0] p0;
      logic [15:0] f;
      m0 = div_main;
      p0 = div_pre;
      f = 16'(s * 4099 + 3);
      run(2'd0, m0, p0, 3'(s), f, 0);
      chk("R2 fast path done next cycle", n_run, 0);
      chk("R2 fast path never busy", saw_busy, 0);
      chk("R2 fast path pins untouched", {pll_resetn, pll_bypass, pll_lock_sel}, 3'b101);
      chk("R12 fast path post and fraction", {div_post, div_frac}, {3'(s), f});
    end

    // R9 rejected requests
    begin
      logic [31:0] snap;
      snap = {div_main, div_pre, div_post, pll_resetn, pll_bypass};
      run(2'd0, 10'd500, 6'd0, 3'd2, 16'd1, 0);
      chk("R9 zero pre rejected with err", {got_done, got_err}, 2'b11);
      chk("R9 zero pre changes nothing", {div_main, div_pre, div_post, pll_resetn, pll_bypass}, snap);
      run(2'd3, 10'd9, 6'd9, 3'd1, 16'd1, 0);
      chk("R9 reserved op rejected with err", {got_done, got_err}, 2'b11);
      chk("R9 reserved op changes nothing", {div_main, div_pre, div_post, pll_resetn, pll_bypass}, snap);
    end

    // R10 request during a running relock
    lock_dly = 6;
    run(2'd0, 10'd321, 6'd5, 3'd6, 16'hBEEF, 1);
    chk("R10 in-flight request ignored", {div_main, div_pre, div_post, div_frac},
        {10'd321, 6'd5, 3'd6, 16'hBEEF});
    chk("R10 sequence completed cleanly", got_err, 0);

    // R5 lock and timeout in the same cycle: lock wins
    lock_dly = TO_CYC - 3;
    run(2'd0, 10'd400, 6'd7, 3'd0, 16'd0, 0);
    chk("R5 lock at expiry edge succeeds", got_err, 0);
    chk("R5 bypass cleared at expiry edge", pll_bypass, 0);

    // R6 lock one cycle too late
    lock_dly = TO_CYC - 2;
    run(2'd0, 10'd401, 6'd7, 3'd0, 16'd0, 0);
    chk("R6 late lock gives err", {got_done, got_err}, 2'b11);
    chk("R6 bypass and reset left high", {pll_bypass, pll_resetn}, 2'b11);

    // R8 power-down
    run(2'd2, 0, 0, 0, 0, 0);
    chk("R8 power-down done next cycle", {n_run[7:0], got_err}, 9'd0);
    chk("R8 reset driven low", pll_resetn, 0);
    chk("R8 bypass and dividers kept", {pll_bypass, div_main, div_pre}, {1'b1, 10'd401, 6'd7});

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule